// File: doc/BRIEF.md
# Oversampling Line Clock Recovery

This block takes the two return-to-zero pulse rails from a line slicer, one rail for positive marks and one for negative marks, and rebuilds a bit clock and retimed data from them. It runs from a reference clock at sixteen times the nominal line rate. A tick counter splits each bit into a sixteen-tick cell. The tick at which each incoming pulse edge lands inside that cell steers the counter by at most one tick per bit. The marks collected in each cell are released as NRZ data. The data changes only while the recovered clock is low, so a downstream register can capture it on the rising edge of the recovered clock.

When recovery is enabled, the outputs carry the recovered clock and the NRZ data. The data appears either as two polarity rails or as one merged data rail, depending on a select input. When recovery is disabled, the slicer rails go straight to the data outputs with no retiming, and the clock output carries the analog loss-of-signal flag in place of a clock.

Top module: `rx_clock_recovery`

## Requirements
- R1: After reset the recovered clock starts high and both data outputs are 0. With no pulse edges arriving, the recovered clock runs at exactly one sixteenth of the reference: 8 ticks high, then 8 ticks low.
- R2: The recovered clock is high for exactly 8 reference ticks in every period. Its low time is always 7, 8 or 9 ticks, including while the phase is being pulled.
- R3: A period of the recovered clock lasts 15, 16 or 17 ticks. It follows a line running slower or faster than nominal, and no mark is lost or duplicated.
- R4: With recovery enabled and dual-rail output selected (dual_rail_i = 1), a pulse on rx_pos_i gives a 1 on rpos_o for one bit and a pulse on rx_neg_i gives a 1 on rneg_o for one bit. The NRZ outputs hold their value across the rising edge of rclk_o.
- R5: With recovery enabled and single-rail output selected (dual_rail_i = 0), rpos_o is 1 for a bit that carried a pulse on either rail, and rneg_o stays 0.
- R6: With recovery disabled (cdr_en_i = 0), rpos_o follows rx_pos_i and rneg_o follows rx_neg_i without passing through any register, and rclk_o follows alos_i.
- R7: The first mark sent after reset shows up on the data outputs within three rising edges of rclk_o, whatever the starting phase.
- R8: Once locked to a line at exactly the nominal rate, the block makes no further corrections, and every period is 16 ticks.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Reference clock at sixteen times the line rate |
| rst_ni | input | 1 | Asynchronous active-low reset |
| cdr_en_i | input | 1 | 1 = recover clock and data, 0 = bypass |
| dual_rail_i | input | 1 | 1 = polarity rails out, 0 = merged data rail |
| rx_pos_i | input | 1 | Positive-mark RZ pulse rail from the slicer |
| rx_neg_i | input | 1 | Negative-mark RZ pulse rail from the slicer |
| alos_i | input | 1 | Analog loss-of-signal flag |
| rclk_o | output | 1 | Recovered clock, or alos_i in bypass |
| rpos_o | output | 1 | Positive NRZ data or merged data; raw rx_pos_i in bypass |
| rneg_o | output | 1 | Negative NRZ data or 0; raw rx_neg_i in bypass |

## Verification
The bench measures every high run and low run of the recovered clock. A design that stretched the high phase to absorb a correction would produce a 9-tick high run and break the duty bound. A design with an idle drift would show periods other than 16 when no pulses arrive. Lines with a 17-tick or 15-tick bit every fourth bit push the phase loop; a loop that corrected too weakly, or in the wrong direction, would drop or repeat marks, and the scoreboard would see the bit stream shift. The bench also times the arrival of the first mark after reset, confirms that the periods return to 16 ticks after lock, and confirms that the bypass outputs react with no clock edge in between.

// File: rtl/rx_clock_recovery_pkg.sv
package rx_clock_recovery_pkg;

  // Per-cell correction the phase counter applies to its low phase
  typedef enum logic [1:0] {
    ADJ_NONE  = 2'd0,
    ADJ_SHORT = 2'd1,
    ADJ_LONG  = 2'd2
  } adj_e;

  localparam int unsigned RAILS = 2;
  localparam int unsigned RAIL_POS = 0;
  localparam int unsigned RAIL_NEG = 1;

endpackage

// File: rtl/rx_rail_edge.sv
module rx_rail_edge #(
  parameter int unsigned STAGES = 2
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic rail_i,
  output logic edge_o
);

  logic [STAGES-1:0] sync_q;
  logic [STAGES-1:0] sync_d;
  logic              last_q;
  logic              last_d;

  for (genvar i = 0; i < STAGES; i++) begin : g_stage
    if (i == 0) begin : g_first
      assign sync_d[i] = rail_i;
    end else begin : g_next
      assign sync_d[i] = sync_q[i-1];
    end
  end

  assign last_d = sync_q[STAGES-1];
  assign edge_o = sync_q[STAGES-1] & ~last_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      sync_q <= '0;
      last_q <= 1'b0;
    end else begin
      sync_q <= sync_d;
      last_q <= last_d;
    end
  end

endmodule

// File: rtl/rx_phase_counter.sv
module rx_phase_counter
  import rx_clock_recovery_pkg::*;
#(
  parameter int unsigned OSR = 16,
  parameter int unsigned TGT = 4
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic edge_i,
  output logic rec_clk_o,
  output logic sample_o
);

  localparam int unsigned HALF   = OSR / 2;
  localparam int unsigned CW     = $clog2(OSR + 2);
  localparam int unsigned SAMPLE = TGT + HALF - 1;
  localparam int unsigned END_N  = OSR - 1;

  logic [CW-1:0] cnt_q, cnt_d;
  adj_e          adj_q, adj_d, adj_eff;
  logic          clk_q, clk_d;
  logic [CW-1:0] end_tick;
  logic          wrap;

  function automatic adj_e classify(input logic [CW-1:0] pos);
    if (pos == CW'(TGT)) begin
      return ADJ_NONE;
    end else if ((pos > CW'(TGT)) && (pos < CW'(TGT + HALF))) begin
      return ADJ_LONG;
    end else begin
      return ADJ_SHORT;
    end
  endfunction

  always_comb begin
    adj_eff = edge_i ? classify(cnt_q) : adj_q;
    case (adj_eff)
      ADJ_SHORT: end_tick = CW'(END_N - 1);
      ADJ_LONG:  end_tick = CW'(END_N + 1);
      default:   end_tick = CW'(END_N);
    endcase
    wrap  = (cnt_q >= end_tick);
    cnt_d = wrap ? '0 : cnt_q + 1'b1;
    adj_d = wrap ? ADJ_NONE : adj_eff;
    clk_d = (cnt_d < CW'(HALF));
  end

  assign sample_o  = (cnt_q == CW'(SAMPLE));
  assign rec_clk_o = clk_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      cnt_q <= '0;
      adj_q <= ADJ_NONE;
      clk_q <= 1'b1;
    end else begin
      cnt_q <= cnt_d;
      adj_q <= adj_d;
      clk_q <= clk_d;
    end
  end

endmodule

// File: rtl/rx_mark_sampler.sv
module rx_mark_sampler
  import rx_clock_recovery_pkg::*;
(
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic [RAILS-1:0] edge_i,
  input  logic             sample_i,
  output logic [RAILS-1:0] nrz_o
);

  logic [RAILS-1:0] acc_q, acc_d;
  logic [RAILS-1:0] nrz_q, nrz_d;
  logic             nrz_en;

  always_comb begin
    nrz_en = sample_i;
    nrz_d  = acc_q | edge_i;
    acc_d  = sample_i ? '0 : (acc_q | edge_i);
  end

  assign nrz_o = nrz_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      acc_q <= '0;
    end else begin
      acc_q <= acc_d;
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      nrz_q <= '0;
    end else if (nrz_en) begin
      nrz_q <= nrz_d;
    end
  end

endmodule

// File: rtl/rx_clock_recovery.sv
module rx_clock_recovery
  import rx_clock_recovery_pkg::*;
#(
  parameter int unsigned OSR         = 16,
  parameter int unsigned TGT         = 4,
  parameter int unsigned SYNC_STAGES = 2
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic cdr_en_i,
  input  logic dual_rail_i,
  input  logic rx_pos_i,
  input  logic rx_neg_i,
  input  logic alos_i,
  output logic rclk_o,
  output logic rpos_o,
  output logic rneg_o
);

  logic [RAILS-1:0] rails;
  logic [RAILS-1:0] edges;
  logic [RAILS-1:0] nrz;
  logic             edge_any;
  logic             rec_clk;
  logic             sample;
  logic             nrz_pos;
  logic             nrz_neg;

  assign rails[RAIL_POS] = rx_pos_i;
  assign rails[RAIL_NEG] = rx_neg_i;

  for (genvar r = 0; r < RAILS; r++) begin : g_rail
    rx_rail_edge #(
      .STAGES(SYNC_STAGES)
    ) u_edge (
      .clk_i (clk_i),
      .rst_ni(rst_ni),
      .rail_i(rails[r]),
      .edge_o(edges[r])
    );
  end

  assign edge_any = |edges;

  rx_phase_counter #(
    .OSR(OSR),
    .TGT(TGT)
  ) u_phase (
    .clk_i    (clk_i),
    .rst_ni   (rst_ni),
    .edge_i   (edge_any),
    .rec_clk_o(rec_clk),
    .sample_o (sample)
  );

  rx_mark_sampler u_marks (
    .clk_i   (clk_i),
    .rst_ni  (rst_ni),
    .edge_i  (edges),
    .sample_i(sample),
    .nrz_o   (nrz)
  );

  assign nrz_pos = nrz[RAIL_POS];
  assign nrz_neg = nrz[RAIL_NEG];

  always_comb begin
    if (cdr_en_i) begin
      rclk_o = rec_clk;
      rpos_o = dual_rail_i ? nrz_pos : (nrz_pos | nrz_neg);
      rneg_o = dual_rail_i ? nrz_neg : 1'b0;
    end else begin
      rclk_o = alos_i;
      rpos_o = rx_pos_i;
      rneg_o = rx_neg_i;
    end
  end

endmodule

// File: rtl/rx_clock_recovery_chk.sv
module rx_clock_recovery_chk #(
  parameter int unsigned OSR = 16
) (
  input logic clk,
  input logic rst_n,
  input logic cdr_en,
  input logic dual,
  input logic rneg,
  input logic rec_clk,
  input logic nrz_pos,
  input logic nrz_neg,
  input logic edge_any
);

  localparam int unsigned HALF = OSR / 2;

  logic       prev_q;
  logic [5:0] run_q;
  logic [5:0] per_q;
  logic       seen_q;
  logic       pvalid_q;
  logic       rise;
  logic       fall;

  assign rise = rec_clk & ~prev_q;
  assign fall = ~rec_clk & prev_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      prev_q   <= 1'b1;
      run_q    <= '0;
      per_q    <= '0;
      seen_q   <= 1'b0;
      pvalid_q <= 1'b0;
    end else begin
      prev_q <= rec_clk;
      run_q  <= (rise | fall) ? 6'd1 : run_q + 6'd1;
      per_q  <= rise ? 6'd1 : per_q + 6'd1;
      seen_q <= rise ? edge_any : (seen_q | edge_any);
      if (rise) begin
        pvalid_q <= 1'b1;
      end
    end
  end

  assert_high_run_R2: assert property (@(posedge clk) disable iff (!rst_n)
    fall |-> (run_q == 6'(HALF)));

  assert_low_run_R2: assert property (@(posedge clk) disable iff (!rst_n)
    rise |-> ((run_q >= 6'(HALF - 1)) && (run_q <= 6'(HALF + 1))));

  assert_period_span_R3: assert property (@(posedge clk) disable iff (!rst_n)
    (rise && pvalid_q) |-> ((per_q >= 6'(OSR - 1)) && (per_q <= 6'(OSR + 1))));

  assert_free_run_R1: assert property (@(posedge clk) disable iff (!rst_n)
    (rise && pvalid_q && !seen_q) |-> (per_q == 6'(OSR)));

  assert_data_hold_R4: assert property (@(posedge clk) disable iff (!rst_n)
    rise |-> $stable({nrz_pos, nrz_neg}));

  assert_single_neg_R5: assert property (@(posedge clk) disable iff (!rst_n)
    (cdr_en && !dual) |-> !rneg);

endmodule

bind rx_clock_recovery rx_clock_recovery_chk #(.OSR(OSR)) u_chk (
  .clk     (clk_i),
  .rst_n   (rst_ni),
  .cdr_en  (cdr_en_i),
  .dual    (dual_rail_i),
  .rneg    (rneg_o),
  .rec_clk (rec_clk),
  .nrz_pos (nrz_pos),
  .nrz_neg (nrz_neg),
  .edge_any(edge_any)
);

// File: tb/rx_clock_recovery_test.sv
module rx_clock_recovery_test;

  localparam int OSR  = 16;
  localparam int HALF = OSR / 2;

  logic clk = 1'b0;
  always #10 clk = ~clk;

  logic rst_n, cdr_en, dual, rx_pos, rx_neg, alos;
  logic rclk, rpos, rneg;

  rx_clock_recovery uut (
    .clk_i      (clk),
    .rst_ni     (rst_n),
    .cdr_en_i   (cdr_en),
    .dual_rail_i(dual),
    .rx_pos_i   (rx_pos),
    .rx_neg_i   (rx_neg),
    .alos_i     (alos),
    .rclk_o     (rclk),
    .rpos_o     (rpos),
    .rneg_o     (rneg)
  );

  int    checks = 0;
  int    errors = 0;
  string tag = "R4";
  logic [1:0] expq[$];
  bit    mon_on = 0;
  bit    armed = 0;
  int    rises = 0;
  int    arm_rise = 0;
  int    nonnom = 0;
  bit    pol = 0;
  bit    done = 0;

  task automatic check(input bit ok, input string req, input int act, input int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  // Monitor: clock shape and scoreboard, sampled away from the active edge
  logic       prev_r = 1'b1;
  int         hi = 0, lo = 0, per = 0;
  bit         dvalid = 0, pvalid = 0;
  logic [1:0] item, e;

  always @(negedge clk) begin
    if (!rst_n || !cdr_en) begin
      dvalid = 0; pvalid = 0; prev_r = rclk; hi = 0; lo = 0; per = 0;
    end else begin
      if (rclk && !prev_r) begin
        rises++;
        if (dvalid) check(lo >= HALF - 1 && lo <= HALF + 1, "R2 low run", lo, HALF);
        if (pvalid) begin
          check(per >= OSR - 1 && per <= OSR + 1, "R3 period span", per, OSR);
          if (per != OSR) nonnom++;
        end
        pvalid = dvalid;
        per = 1; hi = 1;
        if (mon_on) begin
          item = {rpos, rneg};
          if (!armed) begin
            if (item != 2'b00) begin
              armed = 1;
              arm_rise = rises;
              while (expq.size() > 0 && expq[0] == 2'b00) void'(expq.pop_front());
              if (expq.size() == 0) check(0, tag, item, 0);
              else begin e = expq.pop_front(); check(item == e, tag, item, e); end
            end
          end else if (expq.size() > 0) begin
            e = expq.pop_front();
            check(item == e, tag, item, e);
          end
        end
      end else if (!rclk && prev_r) begin
        if (dvalid) check(hi == HALF, "R2 high run", hi, HALF);
        dvalid = 1;
        lo = 1; per++;
      end else begin
        if (rclk) hi++; else lo++;
        per++;
      end
      prev_r = rclk;
    end
  end

  // Driver: one line bit of the given length, expected item pushed first
  task automatic send_bit(input bit p, input bit n, input int plen);
    expq.push_back(dual ? {p, n} : {p | n, 1'b0});
    rx_pos = p; rx_neg = n;
    repeat (HALF) @(negedge clk);
    rx_pos = 0; rx_neg = 0;
    repeat (plen - HALF) @(negedge clk);
  endtask

  task automatic send_word(input logic [31:0] w, input int nbits,
                           input int every, input int alt_len);
    for (int i = 0; i < nbits; i++) begin
      int plen;
      plen = (every > 0 && (i % every) == every - 1) ? alt_len : OSR;
      if (w[i]) begin
        pol = ~pol;
        send_bit(pol, ~pol, plen);
      end else begin
        send_bit(0, 0, plen);
      end
    end
  endtask

  task automatic start_scn(input string t);
    mon_on = 0;
    repeat (3 * OSR) @(negedge clk);
    expq.delete();
    armed = 0;
    tag = t;
    mon_on = 1;
  endtask

  task automatic end_scn();
    int left;
    repeat (4) send_bit(0, 0, OSR);
    repeat (2 * OSR) @(negedge clk);
    mon_on = 0;
    left = 0;
    foreach (expq[i]) if (expq[i] != 2'b00) left++;
    check(left == 0 && armed, {tag, " marks delivered"}, left, 0);
  endtask

  initial begin
    int start_rise;
    rst_n = 0; cdr_en = 1; dual = 1; rx_pos = 0; rx_neg = 0; alos = 0;
    repeat (4) @(negedge clk);
    rst_n = 1;
    #1;
    // R1: reset state
    check(rclk == 1'b1, "R1 reset clock", rclk, 1);
    check(rpos == 1'b0 && rneg == 1'b0, "R1 reset data", {rpos, rneg}, 0);

    // R1: free run with no input
    repeat (2 * OSR) @(negedge clk);
    nonnom = 0;
    start_rise = rises;
    repeat (12 * OSR) @(negedge clk);
    check(nonnom == 0, "R1 free-run period", nonnom, 0);
    check(rises - start_rise >= 11, "R1 free-run rises", rises - start_rise, 12);

    // R7 + R4: acquisition from arbitrary phase, dual-rail data
    repeat (5) @(negedge clk);
    mon_on = 0; expq.delete(); armed = 0; tag = "R4 dual-rail"; mon_on = 1;
    start_rise = rises;
    send_word(32'hD6B5_3A6F, 32, 0, OSR);
    check(armed && (arm_rise - start_rise) <= 3, "R7 first mark delay",
          arm_rise - start_rise, 3);
    end_scn();

    // R8: locked at nominal rate, no corrections
    start_scn("R8 nominal");
    send_word(32'hFFFF_FFFF, 32, 0, OSR);
    nonnom = 0;
    send_word(32'hFFFF_FFFF, 24, 0, OSR);
    check(nonnom == 0, "R8 corrections after lock", nonnom, 0);
    end_scn();

    // R3: slow line
    start_scn("R3 slow line");
    nonnom = 0;
    send_word(32'hFFFF_FFFF, 32, 4, OSR + 1);
    send_word(32'hEFBE_FBDF, 32, 4, OSR + 1);
    check(nonnom > 0, "R3 slow tracking corrections", nonnom, 1);
    end_scn();

    // R3: fast line
    start_scn("R3 fast line");
    nonnom = 0;
    send_word(32'hFFFF_FFFF, 32, 4, OSR - 1);
    send_word(32'hF7DF_7EFB, 32, 4, OSR - 1);
    check(nonnom > 0, "R3 fast tracking corrections", nonnom, 1);
    end_scn();

    // R5: single-rail output
    dual = 0;
    start_scn("R5 single-rail");
    send_word(32'h9B5E_C6A7, 32, 0, OSR);
    end_scn();
    dual = 1;

    // R6: bypass, no register in the path
    @(negedge clk);
    cdr_en = 0; alos = 0;
    rx_pos = 1; #1;
    check(rpos == 1'b1 && rneg == 1'b0, "R6 pos pass-through", {rpos, rneg}, 2);
    rx_pos = 0; rx_neg = 1; #1;
    check(rpos == 1'b0 && rneg == 1'b1, "R6 neg pass-through", {rpos, rneg}, 1);
    rx_neg = 0; alos = 1; #1;
    check(rclk == 1'b1, "R6 clock pin carries alos high", rclk, 1);
    alos = 0; #1;
    check(rclk == 1'b0, "R6 clock pin carries alos low", rclk, 0);
    begin
      int toggles;
      toggles = 0;
      for (int i = 0; i < 3 * OSR; i++) begin
        @(negedge clk);
        if (rclk != 1'b0) toggles++;
      end
      check(toggles == 0, "R6 no recovered clock in bypass", toggles, 0);
    end
    dual = 0; rx_pos = 1; #1;
    check(rpos == 1'b1, "R6 bypass ignores rail select", rpos, 1);
    rx_pos = 0; dual = 1;

    // back to recovery: R4 again after bypass
    cdr_en = 1;
    start_scn("R4 after bypass");
    send_word(32'h5A5A_A5A5, 32, 0, OSR);
    end_scn();

    done = 1;
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    repeat (150000) @(posedge clk);
    if (!done) begin
      checks++;
      errors++;
      $display("FAIL watchdog actual=%0d expected=%0d", 0, 1);
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

endmodule